// File: doc/BRIEF.md
# Oldest-First Squash Request Arbiter

This block sits at the end of an execute stage that resolves several instructions per cycle. Each execute lane can report, for one hardware thread, a branch misprediction, a memory-order violation, or both. The arbiter walks the lanes in index order and folds their reports into one squash record per thread. Each record holds a valid bit, a sequence number, a restart PC, a taken flag, an include flag and a flag showing that a mispredicting branch caused the squash. The record is registered and goes to the commit stage in the next cycle.

The two sources use different rules. A branch replaces the pending record only if it is strictly older. It restarts at its corrected target and keeps itself. A memory-order violation replaces the record when its violator is older than or as old as the pending squash. It restarts at the violator's own PC and marks the violator for re-execution.

A per-thread redirect flag exists only for the length of one cycle. Once a thread is redirecting, a later lane can act only when the pending squash is younger than that lane's instruction. Running counters record mispredictions by predicted direction, their total, and the memory-order violations that were seen.

Top module: `squash_arbiter`

## Requirements
- R1: The record for the lane reports sampled at one rising edge appears on the sq_* outputs right after that edge. In a cycle where no lane causes a squash for a thread, every sq_* field of that thread reads zero, so an old squash is never repeated.
- R2: When a branch squash is accepted into a record, it sets sq_seq to the lane sequence number, sq_pc to lane_target, sq_taken to lane_taken, sq_include to 0 and sq_has_misp to 1.
- R3: When a memory-order squash is accepted into a record, it sets sq_seq to lane_viol_seq, sq_pc to lane_viol_pc, sq_taken to 0, sq_include to 1 and sq_has_misp to 0.
- R4: Lanes are taken in ascending index order. A lane acts only when its thread has no redirect yet in this cycle or the pending sequence number is strictly greater than the lane's lane_seq. A branch replaces the record only if no squash is pending or its sequence number is strictly smaller, so of two branches with equal sequence numbers the lower lane wins.
- R5: A misprediction flagged with lane_unexec_load=1 causes no squash and no count. If the same lane also flags a violation, that violation is handled as a violation.
- R6: A violation on a lane that fails the R4 test adds one to cnt_violation and leaves the record unchanged.
- R7: A violation on a lane that passes the R4 test sets the redirect and adds one to cnt_violation. It replaces the record only if no squash is pending or lane_viol_seq is less than or equal to the pending sequence number.
- R8: Each accepted branch squash adds one to cnt_pred_taken_wrong when lane_pred_taken=1, and otherwise adds one to cnt_pred_nt_wrong.
- R9: cnt_mispredict always equals cnt_pred_taken_wrong plus cnt_pred_nt_wrong, modulo 2^CNT_W.
- R10: Threads are independent. A lane affects only the record of the thread named by lane_tid.
- R11: While reset is held, and until the first report after it, all outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lane_valid | input | NLANES | Lane carries a resolved instruction |
| lane_tid | input | NLANES x TID_W | Thread of each lane |
| lane_misp | input | NLANES | Lane instruction was mispredicted |
| lane_unexec_load | input | NLANES | Lane instruction is a load that has not executed |
| lane_viol | input | NLANES | Lane detected a memory-order violation |
| lane_seq | input | NLANES x SEQ_W | Sequence number of the lane instruction |
| lane_target | input | NLANES x PC_W | Corrected PC for a misprediction |
| lane_taken | input | NLANES | Corrected path is a taken branch |
| lane_pred_taken | input | NLANES | Branch had been predicted taken |
| lane_viol_seq | input | NLANES x SEQ_W | Sequence number of the violating instruction |
| lane_viol_pc | input | NLANES x PC_W | PC of the violating instruction |
| sq_valid | output | NTHREADS | Squash pending for the thread |
| sq_seq | output | NTHREADS x SEQ_W | Squash sequence number |
| sq_pc | output | NTHREADS x PC_W | Restart PC |
| sq_taken | output | NTHREADS | Restart path is a taken branch |
| sq_include | output | NTHREADS | Squash includes the instruction at sq_seq |
| sq_has_misp | output | NTHREADS | Record comes from a mispredicting branch |
| cnt_pred_taken_wrong | output | CNT_W | Accepted mispredictions predicted taken |
| cnt_pred_nt_wrong | output | CNT_W | Accepted mispredictions predicted not taken |
| cnt_mispredict | output | CNT_W | Total accepted mispredictions |
| cnt_violation | output | CNT_W | Memory-order violations seen |

## Verification
A wrong compare direction, a swapped equality rule or a wrong lane order shows up as a wrong sq_seq, sq_pc or sq_include in the cycle right after the reports. Nothing is held across cycles except the counters, so a record error appears within one cycle and does not hide behind later traffic. A counting error, for example on gated violations or ignored load mispredictions, stays in the counters forever and can be seen after the next edge. The random phase reuses a small range of sequence numbers on purpose, so equal and crossing ages come up often.

// File: rtl/squash_arb_pkg.sv
package squash_arb_pkg;

  // What a single lane did to its thread's record this cycle.
  typedef enum logic [1:0] {
    SQ_NONE   = 2'd0,
    SQ_BRANCH = 2'd1,
    SQ_MEMORD = 2'd2
  } sq_kind_e;

endpackage

// File: rtl/squash_merge_stage.sv
module squash_merge_stage
  import squash_arb_pkg::*;
#(
  parameter int SEQ_W  = 16,
  parameter int PC_W   = 32,
  parameter int TID_W  = 1,
  parameter int THREAD = 0
) (
  input  logic             lane_valid,
  input  logic [TID_W-1:0] lane_tid,
  input  logic             lane_misp,
  input  logic             lane_unexec_load,
  input  logic             lane_viol,
  input  logic [SEQ_W-1:0] lane_seq,
  input  logic [PC_W-1:0]  lane_target,
  input  logic             lane_taken,
  input  logic [SEQ_W-1:0] lane_viol_seq,
  input  logic [PC_W-1:0]  lane_viol_pc,
  input  logic             in_redir,
  input  logic             in_valid,
  input  logic [SEQ_W-1:0] in_seq,
  input  logic [PC_W-1:0]  in_pc,
  input  logic             in_taken,
  input  logic             in_incl,
  input  logic             in_misp,
  output logic             out_redir,
  output logic             out_valid,
  output logic [SEQ_W-1:0] out_seq,
  output logic [PC_W-1:0]  out_pc,
  output logic             out_taken,
  output logic             out_incl,
  output logic             out_misp,
  output sq_kind_e         out_kind,
  output logic             out_viol_seen
);

  logic hit, gate_open, misp_eff, take_br, take_mo, br_win, mo_win;

  always_comb begin
    hit       = lane_valid && (lane_tid == TID_W'(THREAD));
    // Act only if not yet redirecting or the pending squash is younger.
    gate_open = !in_redir || !in_valid || (in_seq > lane_seq);
    misp_eff  = lane_misp && !lane_unexec_load;
    take_br   = hit && gate_open && misp_eff;
    take_mo   = hit && gate_open && !misp_eff && lane_viol;
    br_win    = take_br && (!in_valid || (lane_seq < in_seq));
    mo_win    = take_mo && (!in_valid || (lane_viol_seq <= in_seq));

    out_viol_seen = hit && lane_viol && !(gate_open && misp_eff);
    out_redir     = in_redir || take_br || take_mo;
    if (take_br)      out_kind = SQ_BRANCH;
    else if (take_mo) out_kind = SQ_MEMORD;
    else              out_kind = SQ_NONE;

    out_valid = in_valid;
    out_seq   = in_seq;
    out_pc    = in_pc;
    out_taken = in_taken;
    out_incl  = in_incl;
    out_misp  = in_misp;
    if (br_win) begin
      out_valid = 1'b1;
      out_seq   = lane_seq;
      out_pc    = lane_target;
      out_taken = lane_taken;
      out_incl  = 1'b0;
      out_misp  = 1'b1;
    end else if (mo_win) begin
      out_valid = 1'b1;
      out_seq   = lane_viol_seq;
      out_pc    = lane_viol_pc;
      out_taken = 1'b0;
      out_incl  = 1'b1;
      out_misp  = 1'b0;
    end
  end

endmodule

// File: rtl/squash_event_counter.sv
module squash_event_counter #(
  parameter int N_IN  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  inc,
  output logic [CNT_W-1:0] count
);

  localparam int ADD_W = $clog2(N_IN + 1);

  logic [ADD_W-1:0] add_amt;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    add_amt = '0;
    for (int i = 0; i < N_IN; i++) add_amt = add_amt + ADD_W'(inc[i]);
    cnt_en  = |inc;
    cnt_nxt = count + CNT_W'(add_amt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_nxt;
  end

endmodule

// File: rtl/squash_arbiter.sv
module squash_arbiter
  import squash_arb_pkg::*;
#(
  parameter int NTHREADS = 2,
  parameter int NLANES   = 4,
  parameter int SEQ_W    = 16,
  parameter int PC_W     = 32,
  parameter int CNT_W    = 16,
  localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NLANES-1:0]              lane_valid,
  input  logic [NLANES-1:0][TID_W-1:0]   lane_tid,
  input  logic [NLANES-1:0]              lane_misp,
  input  logic [NLANES-1:0]              lane_unexec_load,
  input  logic [NLANES-1:0]              lane_viol,
  input  logic [NLANES-1:0][SEQ_W-1:0]   lane_seq,
  input  logic [NLANES-1:0][PC_W-1:0]    lane_target,
  input  logic [NLANES-1:0]              lane_taken,
  input  logic [NLANES-1:0]              lane_pred_taken,
  input  logic [NLANES-1:0][SEQ_W-1:0]   lane_viol_seq,
  input  logic [NLANES-1:0][PC_W-1:0]    lane_viol_pc,
  output logic [NTHREADS-1:0]            sq_valid,
  output logic [NTHREADS-1:0][SEQ_W-1:0] sq_seq,
  output logic [NTHREADS-1:0][PC_W-1:0]  sq_pc,
  output logic [NTHREADS-1:0]            sq_taken,
  output logic [NTHREADS-1:0]            sq_include,
  output logic [NTHREADS-1:0]            sq_has_misp,
  output logic [CNT_W-1:0]               cnt_pred_taken_wrong,
  output logic [CNT_W-1:0]               cnt_pred_nt_wrong,
  output logic [CNT_W-1:0]               cnt_mispredict,
  output logic [CNT_W-1:0]               cnt_violation
);

  localparam int NEV = NTHREADS * NLANES;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic [NEV-1:0] ev_tw, ev_nw, ev_br, ev_vi;

  logic [NTHREADS-1:0]            nxt_valid, nxt_taken, nxt_incl, nxt_misp;
  logic [NTHREADS-1:0][SEQ_W-1:0] nxt_seq;
  logic [NTHREADS-1:0][PC_W-1:0]  nxt_pc;
  logic                           rec_en;

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    logic [NLANES:0]            c_redir, c_valid, c_taken, c_incl, c_misp;
    logic [NLANES:0][SEQ_W-1:0] c_seq;
    logic [NLANES:0][PC_W-1:0]  c_pc;

    // Each cycle starts from an empty record.
    assign c_redir[0] = 1'b0;
    assign c_valid[0] = 1'b0;
    assign c_taken[0] = 1'b0;
    assign c_incl[0]  = 1'b0;
    assign c_misp[0]  = 1'b0;
    assign c_seq[0]   = '0;
    assign c_pc[0]    = '0;

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
      sq_kind_e kind;
      logic     viol_seen;

      squash_merge_stage #(
        .SEQ_W (SEQ_W),
        .PC_W  (PC_W),
        .TID_W (TID_W),
        .THREAD(t)
      ) u_stage (
        .lane_valid      (lane_valid[l]),
        .lane_tid        (lane_tid[l]),
        .lane_misp       (lane_misp[l]),
        .lane_unexec_load(lane_unexec_load[l]),
        .lane_viol       (lane_viol[l]),
        .lane_seq        (lane_seq[l]),
        .lane_target     (lane_target[l]),
        .lane_taken      (lane_taken[l]),
        .lane_viol_seq   (lane_viol_seq[l]),
        .lane_viol_pc    (lane_viol_pc[l]),
        .in_redir        (c_redir[l]),
        .in_valid        (c_valid[l]),
        .in_seq          (c_seq[l]),
        .in_pc           (c_pc[l]),
        .in_taken        (c_taken[l]),
        .in_incl         (c_incl[l]),
        .in_misp         (c_misp[l]),
        .out_redir       (c_redir[l+1]),
        .out_valid       (c_valid[l+1]),
        .out_seq         (c_seq[l+1]),
        .out_pc          (c_pc[l+1]),
        .out_taken       (c_taken[l+1]),
        .out_incl        (c_incl[l+1]),
        .out_misp        (c_misp[l+1]),
        .out_kind        (kind),
        .out_viol_seen   (viol_seen)
      );

      assign ev_br[t*NLANES+l] = (kind == SQ_BRANCH);
      assign ev_tw[t*NLANES+l] = (kind == SQ_BRANCH) && lane_pred_taken[l];
      assign ev_nw[t*NLANES+l] = (kind == SQ_BRANCH) && !lane_pred_taken[l];
      assign ev_vi[t*NLANES+l] = viol_seen;
    end

    assign nxt_valid[t] = c_valid[NLANES];
    assign nxt_seq[t]   = c_seq[NLANES];
    assign nxt_pc[t]    = c_pc[NLANES];
    assign nxt_taken[t] = c_taken[NLANES];
    assign nxt_incl[t]  = c_incl[NLANES];
    assign nxt_misp[t]  = c_misp[NLANES];

    // R4: a branch on lane 0 always enters the record, later lanes only make it older.
    p_oldest_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
      (lane_valid[0] && (lane_tid[0] == TID_W'(t)) && lane_misp[0] && !lane_unexec_load[0])
      |=> (sq_valid[t] && (sq_seq[t] <= $past(lane_seq[0]))));

    // R3: a record without a mispredicting branch is a memory-order squash.
    p_memord_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
      (sq_valid[t] && !sq_has_misp[t]) |-> (sq_include[t] && !sq_taken[t]));
  end

  // Fields are zero when invalid, so an all-zero record need not be reloaded.
  assign rec_en = (|nxt_valid) || (|sq_valid);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sq_valid    <= '0;
      sq_seq      <= '0;
      sq_pc       <= '0;
      sq_taken    <= '0;
      sq_include  <= '0;
      sq_has_misp <= '0;
    end else if (rec_en) begin
      sq_valid    <= nxt_valid;
      sq_seq      <= nxt_seq;
      sq_pc       <= nxt_pc;
      sq_taken    <= nxt_taken;
      sq_include  <= nxt_incl;
      sq_has_misp <= nxt_misp;
    end
  end

  squash_event_counter #(.N_IN(NEV), .CNT_W(CNT_W)) u_cnt_tw (
    .clk(clk), .rst_n(rst_q_n), .inc(ev_tw), .count(cnt_pred_taken_wrong));
  squash_event_counter #(.N_IN(NEV), .CNT_W(CNT_W)) u_cnt_nw (
    .clk(clk), .rst_n(rst_q_n), .inc(ev_nw), .count(cnt_pred_nt_wrong));
  squash_event_counter #(.N_IN(NEV), .CNT_W(CNT_W)) u_cnt_br (
    .clk(clk), .rst_n(rst_q_n), .inc(ev_br), .count(cnt_mispredict));
  squash_event_counter #(.N_IN(NEV), .CNT_W(CNT_W)) u_cnt_vi (
    .clk(clk), .rst_n(rst_q_n), .inc(ev_vi), .count(cnt_violation));

  // R1: no reports means no squash in the following cycle.
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lane_valid == '0) |=> ((sq_valid == '0) && (sq_seq == '0)));

  // R5: a lone unexecuted-load mispredict raises nothing.
  p_unexec_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((lane_valid == NLANES'(1)) && lane_misp[0] && lane_unexec_load[0] && !lane_viol[0])
    |=> (sq_valid == '0));

  // R6: the violation count moves only when some lane reports one.
  p_viol_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((lane_valid & lane_viol) == '0) |=> $stable(cnt_violation));

  // R9: the total counter tracks the two direction counters.
  p_total_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    cnt_mispredict == CNT_W'(cnt_pred_taken_wrong + cnt_pred_nt_wrong));

endmodule

// File: tb/tb_squash_arbiter.sv
module tb_squash_arbiter;
  localparam int NT    = 2;
  localparam int NL    = 4;
  localparam int SEQ_W = 16;
  localparam int PC_W  = 32;
  localparam int CNT_W = 16;
  localparam int TID_W = 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                        rst_n;
  logic [NL-1:0]               lane_valid, lane_misp, lane_unexec_load, lane_viol;
  logic [NL-1:0]               lane_taken, lane_pred_taken;
  logic [NL-1:0][TID_W-1:0]    lane_tid;
  logic [NL-1:0][SEQ_W-1:0]    lane_seq, lane_viol_seq;
  logic [NL-1:0][PC_W-1:0]     lane_target, lane_viol_pc;
  logic [NT-1:0]               sq_valid, sq_taken, sq_include, sq_has_misp;
  logic [NT-1:0][SEQ_W-1:0]    sq_seq;
  logic [NT-1:0][PC_W-1:0]     sq_pc;
  logic [CNT_W-1:0]            cnt_pred_taken_wrong, cnt_pred_nt_wrong, cnt_mispredict, cnt_violation;

  squash_arbiter #(.NTHREADS(NT), .NLANES(NL), .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .lane_valid(lane_valid), .lane_tid(lane_tid), .lane_misp(lane_misp),
    .lane_unexec_load(lane_unexec_load), .lane_viol(lane_viol), .lane_seq(lane_seq),
    .lane_target(lane_target), .lane_taken(lane_taken), .lane_pred_taken(lane_pred_taken),
    .lane_viol_seq(lane_viol_seq), .lane_viol_pc(lane_viol_pc),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_pc(sq_pc), .sq_taken(sq_taken),
    .sq_include(sq_include), .sq_has_misp(sq_has_misp),
    .cnt_pred_taken_wrong(cnt_pred_taken_wrong), .cnt_pred_nt_wrong(cnt_pred_nt_wrong),
    .cnt_mispredict(cnt_mispredict), .cnt_violation(cnt_violation)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  longint ex_v [NT], ex_s [NT], ex_p [NT], ex_tk [NT], ex_in [NT], ex_mp [NT];
  longint ex_tw = 0, ex_nw = 0, ex_vi = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_lanes();
    lane_valid = '0; lane_misp = '0; lane_unexec_load = '0; lane_viol = '0;
    lane_taken = '0; lane_pred_taken = '0; lane_tid = '0;
    lane_seq = '0; lane_viol_seq = '0; lane_target = '0; lane_viol_pc = '0;
  endtask

  task automatic set_lane(int l, int tid, bit misp, bit unexec, bit viol, int seq,
                          int tgt, bit taken, bit pred, int vseq, int vpc);
    lane_valid[l]       = 1'b1;
    lane_tid[l]         = TID_W'(tid);
    lane_misp[l]        = misp;
    lane_unexec_load[l] = unexec;
    lane_viol[l]        = viol;
    lane_seq[l]         = SEQ_W'(seq);
    lane_target[l]      = PC_W'(tgt);
    lane_taken[l]       = taken;
    lane_pred_taken[l]  = pred;
    lane_viol_seq[l]    = SEQ_W'(vseq);
    lane_viol_pc[l]     = PC_W'(vpc);
  endtask

  // Expected behaviour from the requirements, applied lane by lane.
  task automatic model();
    for (int t = 0; t < NT; t++) begin
      longint v = 0, s = 0, p = 0, tk = 0, inc = 0, mp = 0;
      bit rd = 0;
      for (int l = 0; l < NL; l++) begin
        if (lane_valid[l] && (int'(lane_tid[l]) == t)) begin
          bit gate = !rd || (v == 0) || (s > longint'(lane_seq[l]));
          bit me   = lane_misp[l] && !lane_unexec_load[l];
          if (gate && me) begin
            rd = 1;
            if (lane_pred_taken[l]) ex_tw++; else ex_nw++;
            if ((v == 0) || (longint'(lane_seq[l]) < s)) begin
              v = 1; s = lane_seq[l]; p = lane_target[l]; tk = lane_taken[l]; inc = 0; mp = 1;
            end
          end else if (lane_viol[l]) begin
            ex_vi++;
            if (gate) begin
              rd = 1;
              if ((v == 0) || (longint'(lane_viol_seq[l]) <= s)) begin
                v = 1; s = lane_viol_seq[l]; p = lane_viol_pc[l]; tk = 0; inc = 1; mp = 0;
              end
            end
          end
        end
      end
      ex_v[t] = v; ex_s[t] = s; ex_p[t] = p; ex_tk[t] = tk; ex_in[t] = inc; ex_mp[t] = mp;
    end
  endtask

  task automatic check_all(string tag);
    for (int t = 0; t < NT; t++) begin
      chk(tag, $sformatf("t%0d valid", t),   longint'(sq_valid[t]),    ex_v[t]);
      chk(tag, $sformatf("t%0d seq", t),     longint'(sq_seq[t]),      ex_s[t]);
      chk(tag, $sformatf("t%0d pc", t),      longint'(sq_pc[t]),       ex_p[t]);
      chk(tag, $sformatf("t%0d taken", t),   longint'(sq_taken[t]),    ex_tk[t]);
      chk(tag, $sformatf("t%0d include", t), longint'(sq_include[t]),  ex_in[t]);
      chk(tag, $sformatf("t%0d misp", t),    longint'(sq_has_misp[t]), ex_mp[t]);
    end
    chk(tag, "cnt taken-wrong", longint'(cnt_pred_taken_wrong), ex_tw & 16'hFFFF);
    chk(tag, "cnt nt-wrong",    longint'(cnt_pred_nt_wrong),    ex_nw & 16'hFFFF);
    chk(tag, "cnt total",       longint'(cnt_mispredict),       (ex_tw + ex_nw) & 16'hFFFF);
    chk(tag, "cnt violation",   longint'(cnt_violation),        ex_vi & 16'hFFFF);
  endtask

  // Inputs are already set after a falling edge; check after the next rise.
  task automatic step(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
    clear_lanes();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    clear_lanes();
    for (int t = 0; t < NT; t++) begin
      ex_v[t] = 0; ex_s[t] = 0; ex_p[t] = 0; ex_tk[t] = 0; ex_in[t] = 0; ex_mp[t] = 0;
    end
    repeat (3) @(negedge clk);
    check_all("R11 reset");
    rst_n = 1'b1;
    repeat (3) step("R11 after release");

    // R2: a single branch, predicted not taken.
    set_lane(0, 0, 1, 0, 0, 10, 'h100, 1, 0, 0, 0);
    step("R2 single branch");
    // R1: an idle cycle drops the old squash.
    step("R1 idle clears");

    // R4: the older branch on a later lane wins.
    set_lane(0, 0, 1, 0, 0, 10, 'h200, 0, 1, 0, 0);
    set_lane(1, 0, 1, 0, 0, 5,  'h300, 1, 0, 0, 0);
    step("R4 older later lane");
    // R4: equal age, the lower lane is kept.
    set_lane(0, 0, 1, 0, 0, 7, 'h400, 1, 1, 0, 0);
    set_lane(2, 0, 1, 0, 0, 7, 'h500, 0, 1, 0, 0);
    step("R4 equal age");

    // R5: an unexecuted load mispredict is ignored.
    set_lane(0, 1, 1, 1, 0, 3, 'h600, 1, 1, 0, 0);
    step("R5 unexec load");
    // R5: the same lane's violation is still handled.
    set_lane(0, 1, 1, 1, 1, 3, 'h600, 1, 1, 4, 'h640);
    step("R5 unexec load with violation");

    // R3: a plain violation.
    set_lane(1, 0, 0, 0, 1, 8, 0, 0, 0, 9, 'h700);
    step("R3 violation record");

    // R6: the violation is gated off by an older pending branch.
    set_lane(0, 0, 1, 0, 0, 5, 'h800, 0, 0, 0, 0);
    set_lane(1, 0, 0, 0, 1, 7, 0, 0, 0, 8, 'h880);
    step("R6 gated violation");

    // R7: passes the gate but the violator is younger, so no replacement.
    set_lane(0, 1, 1, 0, 0, 10, 'h900, 1, 1, 0, 0);
    set_lane(3, 1, 0, 0, 1, 3, 0, 0, 0, 12, 'h980);
    step("R7 younger violator");
    // R7: the violator is as old as the pending branch, so it replaces it.
    set_lane(0, 1, 1, 0, 0, 10, 'h900, 1, 1, 0, 0);
    set_lane(1, 1, 0, 0, 1, 3, 0, 0, 0, 10, 'h9C0);
    step("R7 equal violator replaces");

    // R10: threads are kept apart.
    set_lane(0, 0, 1, 0, 0, 20, 'hA00, 1, 1, 0, 0);
    set_lane(1, 1, 0, 0, 1, 2, 0, 0, 0, 2, 'hB00);
    set_lane(2, 1, 1, 0, 0, 1, 'hC00, 0, 0, 0, 0);
    step("R10 two threads");

    // R8 R9: random traffic with a small range of sequence numbers.
    for (int c = 0; c < 400; c++) begin
      for (int l = 0; l < NL; l++) begin
        if ($urandom % 3 != 0)
          set_lane(l, int'($urandom % NT), bit'($urandom % 2), bit'($urandom % 4 == 0),
                   bit'($urandom % 3 == 0), int'($urandom % 16), int'($urandom),
                   bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 16), int'($urandom));
      end
      step("R8 R9 random");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule